// File: doc/BRIEF.md
# Backdoor Key Security Unlock Controller

This block owns the security state of a nonvolatile program memory. After reset it takes a one-time image load of an 8-bit option byte and four 16-bit backdoor key words from the stored array. Bits [1:0] of the option byte are the security field, where binary 10 means unsecured. Bits [7:6] are the key-enable field, where binary 10 permits a backdoor unlock. The option byte is presented as the read-only security status. The CPU has no direct write path to it.

Software unlocks the device by setting a key-access control bit. It then writes the four key words to the key addresses in ascending order and clears the bit. On the clock edge that first samples the bit low, the captured words are compared with the stored key. If the whole entry was valid, the security field is forced to binary 10 and the rest of the byte is kept. While the bit is set, writes to the key address range are held back from the memory array. A fresh option value only takes effect after the next reset and image load.

Top module: `sec_backdoor_unlock`

## Requirements
- R1: After a reset and before any image load, `sec_status` reads 8'hFF and `secured` is 1.
- R2: The first `img_load` after reset copies `img_opt` into `sec_status` at the next edge. The four key words are taken from `img_key`, with word i at bits [16i+15:16i]. Any further `img_load` before the next reset has no effect.
- R3: An unlock happens only when the stored option byte has bits [7:6] equal to binary 10.
- R4: Suppose the words written while `key_acc` is high go to 0xFF00, 0xFF02, 0xFF04 and 0xFF06 in that order, each equal to the stored word. Then on the edge that first samples `key_acc` low, `sec_status[1:0]` becomes binary 10, bits [7:2] stay unchanged, and `secured` drops to 0.
- R5: The device stays secured after the clear if any of the following occurred while `key_acc` was high: a write out of order, a write to any other address, a data mismatch, or a write after the fourth.
- R6: Fewer than four key writes before the clear leave the device secured.
- R7: If any stored key word is 0x0000 or 0xFFFF, no entry ever unlocks.
- R8: While `key_acc` is high, CPU writes to 0xFF00 to 0xFF07 do not assert `array_we`. All other writes, and all writes while `key_acc` is low, drive `array_we` in the same cycle.
- R9: A write made in the cycle where `key_acc` is already low is not taken as a key word.
- R10: CPU writes never alter `sec_status` directly, including writes to 0xFF0F. An unsecured state holds until reset, and reset restores 8'hFF.
- R11: Each clear starts a fresh entry, so a failed attempt does not prevent a later correct one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_load | input | 1 | Image load strobe from the reset sequence |
| img_opt | input | 8 | Stored option/security byte |
| img_key | input | 64 | Stored key words, word i at [16i+15:16i] |
| cpu_we | input | 1 | CPU word write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 16 | CPU write data |
| key_acc | input | 1 | Key-access control bit |
| array_we | output | 1 | Write strobe forwarded to the memory array |
| sec_status | output | 8 | Read-only security register |
| secured | output | 1 | 1 unless the security field is binary 10 |

## Verification
A CPU write and the clearing of `key_acc` can occur in the same cycle. The bench provokes this by issuing the fourth correct key word in the cycle where the access bit is driven low. Its reference model expects the write to go straight to the array, expects the word not to be captured, and expects the device to stay secured. A second overlap puts the image load strobe and a pending comparison on the same edge. Because the model's status only changes on the load edge or on the first low sample of the access bit, its per-cycle comparison shows which of the two took effect.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    localparam logic [1:0] SEC_OPEN   = 2'b10;
    localparam logic [1:0] KEYEN_ON   = 2'b10;
    localparam logic [7:0] OPT_ERASED = 8'hFF;

    typedef struct packed {
        logic [1:0] keyen;
        logic [3:0] misc;
        logic [1:0] sec;
    } opt_byte_t;

    typedef enum logic [1:0] {
        EN_IDLE    = 2'd0,
        EN_COLLECT = 2'd1,
        EN_SPOILED = 2'd2
    } entry_phase_e;

    function automatic logic backdoor_open(input opt_byte_t o);
        return o.keyen == KEYEN_ON;
    endfunction

    function automatic logic is_unsecured(input opt_byte_t o);
        return o.sec == SEC_OPEN;
    endfunction

endpackage

// File: rtl/sbu_image_store.sv
module sbu_image_store
    import sbu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_WORDS = 4,
    localparam int KEY_W    = DATA_W * NUM_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             img_load,
    input  logic [7:0]       img_opt,
    input  logic [KEY_W-1:0] img_key,
    input  logic             force_unsec,
    output opt_byte_t        opt_q,
    output logic [KEY_W-1:0] key_q
);

    logic loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opt_q    <= opt_byte_t'(OPT_ERASED);
            key_q    <= '1;
            loaded_q <= 1'b0;
        end else if (img_load && !loaded_q) begin
            opt_q    <= opt_byte_t'(img_opt);
            key_q    <= img_key;
            loaded_q <= 1'b1;
        end else if (force_unsec) begin
            opt_q.sec <= SEC_OPEN;
        end
    end

endmodule

// File: rtl/sbu_key_entry.sv
module sbu_key_entry
    import sbu_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 16,
    parameter int              NUM_WORDS = 4,
    parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFF00,
    localparam int             IDX_W     = $clog2(NUM_WORDS + 1),
    localparam int             STEP      = DATA_W / 8,
    localparam int             KEY_W     = DATA_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_acc,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              close_evt,
    output logic [IDX_W-1:0]  cap_cnt,
    output logic              spoiled,
    output logic [KEY_W-1:0]  cap_words
);

    entry_phase_e      phase_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              acc_q;
    logic [DATA_W-1:0] words_q [NUM_WORDS];
    logic [ADDR_W-1:0] exp_addr;
    logic              slot_free;
    logic              hit;

    assign close_evt = acc_q && !key_acc;
    assign exp_addr  = KEY_BASE + ADDR_W'(int'(cnt_q) * STEP);
    assign slot_free = cnt_q < IDX_W'(NUM_WORDS);
    assign hit       = (phase_q != EN_SPOILED) && slot_free && (cpu_addr == exp_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= EN_IDLE;
            cnt_q   <= '0;
            acc_q   <= 1'b0;
            for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
        end else begin
            acc_q <= key_acc;
            if (close_evt) begin
                phase_q <= EN_IDLE;
                cnt_q   <= '0;
                for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
            end else if (key_acc && cpu_we) begin
                if (hit) begin
                    for (int i = 0; i < NUM_WORDS; i++)
                        if (cnt_q == IDX_W'(i)) words_q[i] <= cpu_wdata;
                    cnt_q   <= cnt_q + 1'b1;
                    phase_q <= EN_COLLECT;
                end else begin
                    phase_q <= EN_SPOILED;
                end
            end
        end
    end

    assign cap_cnt = cnt_q;
    assign spoiled = (phase_q == EN_SPOILED);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
        assign cap_words[g*DATA_W +: DATA_W] = words_q[g];
    end

endmodule

// File: rtl/sbu_key_match.sv
module sbu_key_match
    import sbu_pkg::*;
#(
    parameter int  DATA_W    = 16,
    parameter int  NUM_WORDS = 4,
    localparam int IDX_W     = $clog2(NUM_WORDS + 1),
    localparam int KEY_W     = DATA_W * NUM_WORDS
) (
    input  opt_byte_t        opt,
    input  logic [KEY_W-1:0] stored_key,
    input  logic [KEY_W-1:0] cap_words,
    input  logic [IDX_W-1:0] cap_cnt,
    input  logic             spoiled,
    output logic             unlock_ok
);

    logic [NUM_WORDS-1:0] word_eq;
    logic [NUM_WORDS-1:0] word_legal;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] ref_w;
        logic [DATA_W-1:0] got_w;
        assign ref_w         = stored_key[g*DATA_W +: DATA_W];
        assign got_w         = cap_words[g*DATA_W +: DATA_W];
        assign word_eq[g]    = (ref_w == got_w);
        assign word_legal[g] = (ref_w != '0) && (ref_w != '1);
    end

    assign unlock_ok = backdoor_open(opt)
                    && (cap_cnt == IDX_W'(NUM_WORDS))
                    && !spoiled
                    && (&word_eq)
                    && (&word_legal);

endmodule

// File: rtl/sbu_write_gate.sv
module sbu_write_gate #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                NUM_WORDS = 4,
    parameter logic [ADDR_W-1:0] KEY_BASE  = 16'hFF00,
    localparam int               SPAN      = NUM_WORDS * (DATA_W / 8)
) (
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              key_acc,
    output logic              array_we
);

    logic [ADDR_W:0] lim;
    logic            in_window;

    assign lim       = {1'b0, KEY_BASE} + (ADDR_W+1)'(SPAN);
    assign in_window = (cpu_addr >= KEY_BASE) && ({1'b0, cpu_addr} < lim);
    assign array_we  = cpu_we && !(key_acc && in_window);

endmodule

// File: rtl/sec_backdoor_unlock.sv
module sec_backdoor_unlock
    import sbu_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                NUM_WORDS = 4,
    parameter logic [ADDR_W-1:0] KEY_BASE  = 16'hFF00,
    localparam int               IDX_W     = $clog2(NUM_WORDS + 1),
    localparam int               KEY_W     = DATA_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              img_load,
    input  logic [7:0]        img_opt,
    input  logic [KEY_W-1:0]  img_key,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              key_acc,
    output logic              array_we,
    output logic [7:0]        sec_status,
    output logic              secured
);

    opt_byte_t        opt_q;
    logic [KEY_W-1:0] stored_key;
    logic [KEY_W-1:0] cap_words;
    logic [IDX_W-1:0] cap_cnt;
    logic             spoiled;
    logic             close_evt;
    logic             unlock_ok;
    logic             force_unsec;

    assign force_unsec = close_evt && unlock_ok;

    sbu_image_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .img_load   (img_load),
        .img_opt    (img_opt),
        .img_key    (img_key),
        .force_unsec(force_unsec),
        .opt_q      (opt_q),
        .key_q      (stored_key)
    );

    sbu_key_entry #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .KEY_BASE(KEY_BASE)
    ) u_entry (
        .clk      (clk),
        .rst      (rst),
        .key_acc  (key_acc),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .close_evt(close_evt),
        .cap_cnt  (cap_cnt),
        .spoiled  (spoiled),
        .cap_words(cap_words)
    );

    sbu_key_match #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_match (
        .opt       (opt_q),
        .stored_key(stored_key),
        .cap_words (cap_words),
        .cap_cnt   (cap_cnt),
        .spoiled   (spoiled),
        .unlock_ok (unlock_ok)
    );

    sbu_write_gate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .KEY_BASE(KEY_BASE)
    ) u_gate (
        .cpu_we  (cpu_we),
        .cpu_addr(cpu_addr),
        .key_acc (key_acc),
        .array_we(array_we)
    );

    assign sec_status = opt_q;
    assign secured    = !is_unsecured(opt_q);

endmodule

// File: rtl/sec_backdoor_unlock_chk.sv
module sec_backdoor_unlock_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                NUM_WORDS = 4,
    parameter logic [ADDR_W-1:0] KEY_BASE  = 16'hFF00,
    localparam int               KEY_W     = DATA_W * NUM_WORDS,
    localparam int               SPAN      = NUM_WORDS * (DATA_W / 8)
) (
    input logic              clk,
    input logic              rst,
    input logic              img_load,
    input logic              key_acc,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              array_we,
    input logic [7:0]        sec_status,
    input logic [KEY_W-1:0]  stored_key
);

    logic any_trivial;
    logic in_window;

    always_comb begin
        any_trivial = 1'b0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (stored_key[i*DATA_W +: DATA_W] == '0 || stored_key[i*DATA_W +: DATA_W] == '1)
                any_trivial = 1'b1;
    end

    assign in_window = (int'(cpu_addr) >= int'(KEY_BASE)) &&
                       (int'(cpu_addr) < int'(KEY_BASE) + SPAN);

    // R1
    erased_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sec_status == 8'hFF));

    // R2
    upper_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !img_load |=> $stable(sec_status[7:2]));

    // R3
    unlock_needs_keyen_chk: assert property (@(posedge clk) disable iff (rst)
        !img_load |=> ($stable(sec_status[1:0]) ||
                       (sec_status[1:0] == 2'b10 && sec_status[7:6] == 2'b10)));

    // R9
    unlock_only_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!img_load && !$fell(key_acc)) |=> $stable(sec_status[1:0]));

    // R7
    trivial_key_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!img_load && any_trivial) |=> $stable(sec_status[1:0]));

    // R8
    key_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (key_acc && cpu_we && in_window) |-> !array_we);

    // R8
    plain_write_passes_chk: assert property (@(posedge clk) disable iff (rst)
        !key_acc |-> (array_we == cpu_we));

    // R10
    unsecured_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_status[1:0] == 2'b10 && !img_load) |=> (sec_status[1:0] == 2'b10));

endmodule

bind sec_backdoor_unlock sec_backdoor_unlock_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .KEY_BASE(KEY_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .img_load  (img_load),
    .key_acc   (key_acc),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .array_we  (array_we),
    .sec_status(sec_status),
    .stored_key(stored_key)
);

// File: tb/sec_backdoor_unlock_test.sv
module sec_backdoor_unlock_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        img_load;
    logic [7:0]  img_opt;
    logic [63:0] img_key;
    logic        cpu_we;
    logic [15:0] cpu_addr;
    logic [15:0] cpu_wdata;
    logic        key_acc;
    logic        array_we;
    logic [7:0]  sec_status;
    logic        secured;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    logic [7:0]  m_sec;
    logic [15:0] m_key [4];
    bit          m_loaded;
    logic [15:0] m_cap [$];
    bit          m_bad;
    bit          m_accq;

    localparam logic [63:0] KEYS = {16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};

    always #4 clk = ~clk;

    sec_backdoor_unlock uut (
        .clk(clk), .rst(rst), .img_load(img_load), .img_opt(img_opt), .img_key(img_key),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .key_acc(key_acc),
        .array_we(array_we), .sec_status(sec_status), .secured(secured)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit ok;
        if (rst) begin
            m_sec = 8'hFF; m_loaded = 0; m_cap.delete(); m_bad = 0; m_accq = 0;
            for (int i = 0; i < 4; i++) m_key[i] = 16'hFFFF;
            return;
        end
        if (m_accq && !key_acc) begin
            ok = (m_sec[7:6] == 2'b10) && (m_cap.size() == 4) && !m_bad;
            if (ok)
                for (int i = 0; i < 4; i++)
                    if (m_cap[i] != m_key[i] || m_key[i] == 16'h0000 || m_key[i] == 16'hFFFF) ok = 0;
            m_cap.delete(); m_bad = 0;
            if (ok && !(img_load && !m_loaded)) m_sec[1:0] = 2'b10;
        end else if (key_acc && cpu_we) begin
            if (!m_bad && m_cap.size() < 4 && cpu_addr == 16'hFF00 + 16'(2 * m_cap.size()))
                m_cap.push_back(cpu_wdata);
            else
                m_bad = 1;
        end
        if (img_load && !m_loaded) begin
            m_sec = img_opt; m_loaded = 1;
            for (int i = 0; i < 4; i++) m_key[i] = img_key[16*i +: 16];
        end
        m_accq = key_acc;
    endtask

    task automatic drive(input bit ld, input bit we, input logic [15:0] a,
                         input logic [15:0] d, input bit acc, input string tag);
        bit exp_we;
        img_load = ld; cpu_we = we; cpu_addr = a; cpu_wdata = d; key_acc = acc;
        #1;
        exp_we = we && !(acc && a >= 16'hFF00 && a <= 16'hFF07);
        chk(array_we == exp_we, "R8", 16'(array_we), 16'(exp_we));
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(sec_status == m_sec, tag, 16'(sec_status), 16'(m_sec));
        chk(secured == (m_sec[1:0] != 2'b10), tag, 16'(secured), 16'(m_sec[1:0] != 2'b10));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 16'h0, 16'h0, 0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2, "R1");
        rst = 1'b0;
    endtask

    task automatic load(input logic [7:0] o, input logic [63:0] k, input string tag);
        img_opt = o; img_key = k;
        drive(1, 0, 16'h0, 16'h0, 0, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input string tag);
        drive(0, 1, a, d, 1, tag);
    endtask

    task automatic open_acc(input string tag);
        drive(0, 0, 16'h0, 16'h0, 1, tag);
    endtask

    task automatic close_acc(input string tag);
        drive(0, 0, 16'h0, 16'h0, 0, tag);
    endtask

    task automatic good_entry(input logic [63:0] k, input string tag);
        open_acc(tag);
        for (int i = 0; i < 4; i++) wr(16'hFF00 + 16'(2 * i), k[16*i +: 16], tag);
        close_acc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        img_opt = 8'h00; img_key = '0;
        do_reset();
        idle(2, "R1");
        chk(sec_status == 8'hFF, "R1", 16'(sec_status), 16'hFF);
        chk(secured == 1'b1, "R1", 16'(secured), 16'h1);

        // R2: first load takes, second is ignored
        load(8'hBC, KEYS, "R2");
        chk(sec_status == 8'hBC, "R2", 16'(sec_status), 16'hBC);
        load(8'h3E, 64'h1111_2222_3333_4444, "R2");
        chk(sec_status == 8'hBC, "R2", 16'(sec_status), 16'hBC);

        // R8: non-key write passes while access bit set, key write blocked
        open_acc("R8");
        wr(16'h1234, 16'hAAAA, "R8");
        wr(16'hFF00, 16'h1234, "R8");
        close_acc("R5");

        // R5: out of order
        open_acc("R5");
        wr(16'hFF02, KEYS[31:16], "R5");
        wr(16'hFF00, KEYS[15:0], "R5");
        wr(16'hFF04, KEYS[47:32], "R5");
        wr(16'hFF06, KEYS[63:48], "R5");
        close_acc("R5");
        chk(secured == 1'b1, "R5", 16'(secured), 16'h1);

        // R5: data mismatch on third word
        open_acc("R5");
        wr(16'hFF00, KEYS[15:0], "R5");
        wr(16'hFF02, KEYS[31:16], "R5");
        wr(16'hFF04, 16'h9ABD, "R5");
        wr(16'hFF06, KEYS[63:48], "R5");
        close_acc("R5");

        // R5: wrong address in the middle
        open_acc("R5");
        wr(16'hFF00, KEYS[15:0], "R5");
        wr(16'hFF08, 16'h0001, "R5");
        wr(16'hFF02, KEYS[31:16], "R5");
        wr(16'hFF04, KEYS[47:32], "R5");
        wr(16'hFF06, KEYS[63:48], "R5");
        close_acc("R5");

        // R5: a fifth write spoils the entry
        open_acc("R5");
        for (int i = 0; i < 4; i++) wr(16'hFF00 + 16'(2 * i), KEYS[16*i +: 16], "R5");
        wr(16'hFF00, KEYS[15:0], "R5");
        close_acc("R5");
        chk(secured == 1'b1, "R5", 16'(secured), 16'h1);

        // R6: only three words
        open_acc("R6");
        for (int i = 0; i < 3; i++) wr(16'hFF00 + 16'(2 * i), KEYS[16*i +: 16], "R6");
        close_acc("R6");
        chk(secured == 1'b1, "R6", 16'(secured), 16'h1);

        // R9: fourth word lands in the clearing cycle
        open_acc("R9");
        for (int i = 0; i < 3; i++) wr(16'hFF00 + 16'(2 * i), KEYS[16*i +: 16], "R9");
        drive(0, 1, 16'hFF06, KEYS[63:48], 0, "R9");
        idle(1, "R9");
        chk(secured == 1'b1, "R9", 16'(secured), 16'h1);

        // R10: CPU write to the security byte address does nothing to status
        drive(0, 1, 16'hFF0F, 16'h00FE, 0, "R10");
        chk(sec_status == 8'hBC, "R10", 16'(sec_status), 16'hBC);

        // R4 and R11: correct entry after the failures
        good_entry(KEYS, "R4");
        chk(sec_status == 8'hBE, "R4", 16'(sec_status), 16'hBE);
        chk(secured == 1'b0, "R11", 16'(secured), 16'h0);

        // R10: sticky until reset
        open_acc("R10");
        wr(16'hFF02, 16'h0000, "R10");
        close_acc("R10");
        idle(3, "R10");
        chk(sec_status == 8'hBE, "R10", 16'(sec_status), 16'hBE);
        do_reset();
        idle(1, "R10");
        chk(sec_status == 8'hFF, "R10", 16'(sec_status), 16'hFF);

        // R3: key-enable field 11 blocks the unlock
        load(8'hFC, KEYS, "R3");
        good_entry(KEYS, "R3");
        chk(secured == 1'b1, "R3", 16'(secured), 16'h1);

        // R7: stored word 0xFFFF
        do_reset();
        load(8'hBC, {16'hDEF0, 16'hFFFF, 16'h5678, 16'h1234}, "R7");
        good_entry({16'hDEF0, 16'hFFFF, 16'h5678, 16'h1234}, "R7");
        chk(secured == 1'b1, "R7", 16'(secured), 16'h1);

        // R7: stored word 0x0000
        do_reset();
        load(8'hBC, {16'hDEF0, 16'h9ABC, 16'h5678, 16'h0000}, "R7");
        good_entry({16'hDEF0, 16'h9ABC, 16'h5678, 16'h0000}, "R7");
        chk(secured == 1'b1, "R7", 16'(secured), 16'h1);

        // R4: other option byte, other bits kept
        do_reset();
        load(8'h80, KEYS, "R4");
        good_entry(KEYS, "R4");
        chk(sec_status == 8'h82, "R4", 16'(sec_status), 16'h82);

        idle(2, "R10");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule